// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits behind a receive path and decides, for each incoming frame, whether its destination address is wanted. The six destination bytes arrive one per accepted beat on a valid/ready byte stream. While they arrive, the block keeps a running Ethernet CRC-32 of them and assembles the full 48-bit address. On the beat that carries the sixth byte it settles the verdict. It presents that verdict as a one-cycle pulse on the following cycle.

An individual address (group bit clear) passes only if it equals the programmed station address. A group address, broadcast included, passes if the mask bit chosen by six bits of its CRC is set in a 64-bit hash mask. A promiscuous bit overrides both rules and passes everything.

The station address, hash mask and mode are loaded through a plain write port of 16-bit words. The stream never applies back-pressure: ready is held high whenever the block is out of reset. Bytes move only on cycles where valid and ready are both high, and idle cycles may appear between bytes.

Top module: `mcast_filter`

## Requirements
- R1: While reset is asserted, `in_ready` and `dec_valid` are low. From the first clock after reset release, `in_ready` is high. All configuration registers reset to zero, so with no writes only the all-zero address is accepted.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_sel`. Code 0 is the mode word, codes 1 to 3 are station words 0 to 2, and codes 4 to 7 are hash words 0 to 3. Codes 8 to 15 change nothing.
- R3: Station word k holds address byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. Byte 0 is the first byte on the stream. An address whose byte 0 bit 0 is clear is accepted only when all 48 bits equal the station address.
- R4: When bit 15 of the mode word is set, every address is accepted. The other mode bits have no effect.
- R5: An address whose byte 0 bit 0 is set is accepted exactly when mask bit h is set. h is bits 31:26 of a CRC register that is preset to all ones, then stepped once per address bit, LSB of each byte first, with polynomial 0x04C11DB7 (shift left, XOR the polynomial when the old bit 31 differs from the input bit). Mask bit h is bit h[3:0] of hash word h[5:4].
- R6: `dec_valid` is high for exactly one cycle: the cycle after the edge that accepts the sixth byte. `dec_accept` carries the verdict in that cycle and is low in every other cycle.
- R7: Only beats with `in_valid` high are counted as bytes. Idle cycles between bytes do not change the result and raise no decision. A new address may start in the cycle that carries the previous decision.
- R8: The all-ones broadcast address gets no special treatment. It is accepted only through its hash bit, or in promiscuous mode.
- R9: A configuration write made in the same cycle as the sixth byte does not affect that address's decision. It applies from the next address on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register code |
| cfg_wdata | input | 16 | Configuration write data |
| in_valid | input | 1 | Address byte present |
| in_ready | output | 1 | Block can take a byte (high out of reset) |
| in_data | input | 8 | Address byte, first byte first |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Verdict, qualified by dec_valid |

## Verification
Two things can happen in the same cycle: a configuration write and the sixth byte of an address. The bench provokes this by writing the promiscuous bit in exactly the cycle of the sixth byte of an address that would otherwise be rejected. It expects that address to be rejected and the next identical address to be accepted. It also clears the bit again alongside a later sixth byte and checks the same ordering in the other direction.

// File: rtl/mcast_filter_pkg.sv
package mcast_filter_pkg;
  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  typedef enum logic [3:0] {
    SEL_MODE = 4'd0,
    SEL_STA0 = 4'd1,
    SEL_STA1 = 4'd2,
    SEL_STA2 = 4'd3,
    SEL_HSH0 = 4'd4,
    SEL_HSH1 = 4'd5,
    SEL_HSH2 = 4'd6,
    SEL_HSH3 = 4'd7
  } cfg_sel_e;

  // One byte, LSB first, MSB-aligned shift register form.
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                     input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[CRC_W-1] ^ d[i]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                   r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/mcast_filter_cfg.sv
module mcast_filter_cfg #(
  parameter int WORD_W     = 16,
  parameter int STA_WORDS  = 3,
  parameter int MASK_WORDS = 4,
  parameter int SEL_W      = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [SEL_W-1:0]               sel,
  input  logic [WORD_W-1:0]              wdata,
  output logic                           promisc,
  output logic [STA_WORDS*WORD_W-1:0]    station,
  output logic [MASK_WORDS*WORD_W-1:0]   mask
);
  localparam int STA_BASE  = 1;
  localparam int MASK_BASE = STA_BASE + STA_WORDS;

  always_ff @(posedge clk) begin
    if (!rst_n)                            promisc <= 1'b0;
    else if (we && sel == SEL_W'(0))       promisc <= wdata[WORD_W-1];
  end

  for (genvar s = 0; s < STA_WORDS; s++) begin : g_sta
    always_ff @(posedge clk) begin
      if (!rst_n)                                station[s*WORD_W +: WORD_W] <= '0;
      else if (we && sel == SEL_W'(STA_BASE + s)) station[s*WORD_W +: WORD_W] <= wdata;
    end
  end

  for (genvar m = 0; m < MASK_WORDS; m++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)                                 mask[m*WORD_W +: WORD_W] <= '0;
      else if (we && sel == SEL_W'(MASK_BASE + m)) mask[m*WORD_W +: WORD_W] <= wdata;
    end
  end
endmodule

// File: rtl/mcast_filter_crc.sv
module mcast_filter_crc
  import mcast_filter_pkg::*;
#(
  parameter int HASH_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              last,
  input  logic [7:0]        data,
  output logic [HASH_W-1:0] hash_idx
);
  logic [CRC_W-1:0] crc_q, crc_nxt;

  assign crc_nxt  = crc_step_byte(crc_q, data);
  assign hash_idx = crc_nxt[CRC_W-1 -: HASH_W];

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= '1;
    else if (beat) crc_q <= last ? '1 : crc_nxt;
  end
endmodule

// File: rtl/mcast_filter_collect.sv
module mcast_filter_collect #(
  parameter int BYTES = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat,
  input  logic [7:0]         data,
  output logic               last,
  output logic [BYTES*8-1:0] addr_now
);
  localparam int CNT_W = $clog2(BYTES);

  logic [CNT_W-1:0]   cnt_q;
  logic [BYTES*8-1:0] addr_q;

  assign last = (cnt_q == CNT_W'(BYTES - 1));

  always_comb begin
    addr_now = addr_q;
    for (int i = 0; i < BYTES; i++)
      if (cnt_q == CNT_W'(i)) addr_now[i*8 +: 8] = data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (beat) begin
      addr_q <= addr_now;
      cnt_q  <= last ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mcast_filter.sv
module mcast_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int WORD_W     = 16,
  parameter int MASK_WORDS = 4,
  parameter int SEL_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              dec_valid,
  output logic              dec_accept
);
  localparam int ADDR_W    = ADDR_BYTES * 8;
  localparam int STA_WORDS = ADDR_W / WORD_W;
  localparam int MASK_W    = MASK_WORDS * WORD_W;
  localparam int HASH_W    = $clog2(MASK_W);

  logic              promisc;
  logic [ADDR_W-1:0] station, addr_now;
  logic [MASK_W-1:0] mask;
  logic [HASH_W-1:0] hash_idx;
  logic              beat, last, verdict;

  assign beat = in_valid && in_ready;

  mcast_filter_cfg #(
    .WORD_W(WORD_W), .STA_WORDS(STA_WORDS), .MASK_WORDS(MASK_WORDS), .SEL_W(SEL_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .promisc(promisc), .station(station), .mask(mask)
  );

  mcast_filter_collect #(.BYTES(ADDR_BYTES)) u_col (
    .clk(clk), .rst_n(rst_n), .beat(beat), .data(in_data),
    .last(last), .addr_now(addr_now)
  );

  mcast_filter_crc #(.HASH_W(HASH_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(last), .data(in_data),
    .hash_idx(hash_idx)
  );

  // Group bit is bit 0 of the first byte on the stream.
  always_comb begin
    if (promisc)          verdict = 1'b1;
    else if (addr_now[0]) verdict = mask[hash_idx];
    else                  verdict = (addr_now == station);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready   <= 1'b0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      in_ready   <= 1'b1;
      dec_valid  <= beat && last;
      dec_accept <= beat && last && verdict;
    end
  end
endmodule

// File: rtl/mcast_filter_chk.sv
module mcast_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic dec_valid,
  input logic dec_accept,
  input logic promisc
);
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  p_after_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid && in_ready));

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept);

  p_promisc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(promisc)) |-> dec_accept);

  p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);
endmodule

bind mcast_filter mcast_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .promisc(promisc)
);

// File: tb/tb_mcast_filter.sv
module tb_mcast_filter;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        dec_valid, dec_accept;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] ref_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcast_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      logic fb;
      fb = c[31] ^ a[k];
      c  = c << 1;
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c[31:26];
  endfunction

  task automatic cfg_write(input logic [3:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_mask(input logic [63:0] m);
    for (int w = 0; w < 4; w++) cfg_write(4'(4 + w), m[w*16 +: 16]);
    ref_mask = m;
  endtask

  // Sends six bytes; optional idle gap before each byte; optional config write
  // in the cycle of the sixth byte. Returns the decision seen the cycle after.
  task automatic send(input logic [47:0] a, input int gap, input bit cw,
                      input logic [3:0] cs, input logic [15:0] cd,
                      output logic v, output logic acc);
    for (int i = 0; i < 6; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
        if (g > 0 || i > 0) chk("R7 no decision during gap", 32'(dec_valid), 32'd0);
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = a[i*8 +: 8];
      if (i == 5 && cw) begin cfg_we = 1'b1; cfg_sel = cs; cfg_wdata = cd; end
    end
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    v = dec_valid; acc = dec_accept;
    @(negedge clk);
    chk("R6 decision lasts one cycle", 32'(dec_valid), 32'd0);
    chk("R6 accept low outside decision", 32'(dec_accept), 32'd0);
  endtask

  task automatic expect_dec(input string req, input logic [47:0] a, input logic exp);
    logic v, acc;
    send(a, 0, 1'b0, 4'd0, 16'd0, v, acc);
    chk(req, 32'(v), 32'd1);
    chk(req, 32'(acc), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] sta, a;
    logic v, acc;
    logic [5:0] h;
    ref_mask = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", 32'(in_ready), 32'd0);
    chk("R1 no decision in reset", 32'(dec_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(in_ready), 32'd1);
    expect_dec("R1 zero address matches reset station", 48'h0, 1'b1);
    expect_dec("R1 group address rejected with empty mask", 48'h0000_0000_0001, 1'b0);

    // R3: station byte order and exact match
    sta = 48'h5544_3322_1102;
    cfg_write(4'd1, 16'h1102);
    cfg_write(4'd2, 16'h3322);
    cfg_write(4'd3, 16'h5544);
    expect_dec("R3 exact station match", sta, 1'b1);
    for (int p = 0; p < 6; p++) begin
      a = sta;
      a[p*8 + 1] = ~a[p*8 + 1];
      expect_dec("R3 one bit differs", a, 1'b0);
    end
    expect_dec("R3 swapped word order rejected", 48'h1102_3322_5544, 1'b0);

    // R5: hash sweep, pattern and its complement
    set_mask(64'h5A17_3C96_0F69_A5C3);
    for (int k = 0; k < 64; k++) begin
      a = {8'(k), 8'(k * 7), 8'h00, 8'h5E, 8'h00, 8'h01};
      h = ref_hash(a);
      expect_dec("R5 hash lookup", a, ref_mask[h]);
    end
    set_mask(~64'h5A17_3C96_0F69_A5C3);
    for (int k = 0; k < 64; k++) begin
      a = {8'(k * 3), 8'h11, 8'(k), 8'h22, 8'h44, 8'h33};
      h = ref_hash(a);
      expect_dec("R5 hash lookup inverted", a, ref_mask[h]);
    end
    // every single mask bit alone
    for (int b = 0; b < 64; b++) begin
      logic [63:0] one;
      one = 64'd1 << b;
      set_mask(one);
      a = {8'(b), 8'hC3, 8'h0F, 8'h69, 8'hA5, 8'h03};
      h = ref_hash(a);
      expect_dec("R5 single mask bit", a, (h == 6'(b)));
    end

    // R8: broadcast via its hash only
    h = ref_hash(48'hFFFF_FFFF_FFFF);
    set_mask(64'd1 << h);
    expect_dec("R8 broadcast hash bit set", 48'hFFFF_FFFF_FFFF, 1'b1);
    set_mask(~(64'd1 << h));
    expect_dec("R8 broadcast hash bit clear", 48'hFFFF_FFFF_FFFF, 1'b0);

    // R4: promiscuous bit and other mode bits
    cfg_write(4'd0, 16'h7FFF);
    expect_dec("R4 other mode bits no effect", 48'hABCD_EF01_2340, 1'b0);
    cfg_write(4'd0, 16'h8000);
    expect_dec("R4 promiscuous unicast", 48'hABCD_EF01_2340, 1'b1);
    expect_dec("R4 promiscuous broadcast", 48'hFFFF_FFFF_FFFF, 1'b1);
    cfg_write(4'd0, 16'h0000);
    expect_dec("R4 promiscuous cleared", 48'hABCD_EF01_2340, 1'b0);

    // R2: unused codes change nothing
    for (int c = 8; c < 16; c++) cfg_write(4'(c), 16'hFFFF);
    expect_dec("R2 unused code no promisc", 48'hABCD_EF01_2340, 1'b0);
    expect_dec("R2 unused code station kept", sta, 1'b1);
    expect_dec("R8 unused code mask kept", 48'hFFFF_FFFF_FFFF, 1'b0);

    // R7: idle gaps between bytes
    send(sta, 2, 1'b0, 4'd0, 16'd0, v, acc);
    chk("R7 gaps decision valid", 32'(v), 32'd1);
    chk("R7 gaps decision accept", 32'(acc), 32'd1);

    // R9: write in sixth-byte cycle applies to next address
    a = 48'h0102_0304_0500;
    send(a, 0, 1'b1, 4'd0, 16'h8000, v, acc);
    chk("R9 same-cycle write not used", 32'(acc), 32'd0);
    expect_dec("R9 write used next address", a, 1'b1);
    send(a, 0, 1'b1, 4'd0, 16'h0000, v, acc);
    chk("R9 same-cycle clear not used", 32'(acc), 32'd1);
    expect_dec("R9 clear used next address", a, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule